// File: doc/BRIEF.md
# Low-Transition Test Pattern Generator

This block is a self-test stimulus source for an 8-bit circuit under test. A ring register steps through base test patterns. Before each base pattern is applied, a toggle counter XORs it with the vector currently on the output and sums the differing bits through an adder network. If the sum is above a threshold, a bridging vector goes out first. Its upper half comes from the coming pattern and its lower half from the vector already applied. The base pattern follows on the next cycle. This keeps the switching between consecutive applied vectors low. Well-correlated pattern pairs pass through with no extra cycle.

A small state machine orders the work. The states are `ST_CHECK`, `ST_HOLD` and `ST_DONE`. `ST_CHECK` applies the candidate directly and stays in `ST_CHECK`, or moves to `ST_DONE` after the final pattern. When the count is over the threshold, it applies the bridge and goes to `ST_HOLD`. `ST_HOLD` applies the held candidate and returns to `ST_CHECK`, or goes to `ST_DONE` if that was the final pattern. `ST_DONE` stays put, with `test_done` high and the output frozen. All outputs are registered.

Top module: `ltpg_top`

## Requirements
- R1: A synchronous active-high reset sets `test_vec` to all zeros and clears `vec_valid`, `vec_bridge` and `test_done`. The first base pattern after reset is `SEED`.
- R2: Base pattern k+1 is base pattern k rotated left by one bit, where bit WIDTH-1 wraps to bit 0. Every WIDTH-th step (k+1 a multiple of WIDTH) the rotated value is also complemented.
- R3: The transition count of a candidate is the number of 1 bits in the candidate XOR the vector last applied. All zeros counts as the last applied vector after reset.
- R4: When the transition count is strictly greater than `THRESH`, a bridge vector is applied first, with `vec_bridge`=1 and `vec_valid`=1. Bits WIDTH-1..WIDTH/2 of the bridge come from the candidate and bits WIDTH/2-1..0 come from the previously applied vector.
- R5: When the transition count is less than or equal to `THRESH`, including equality, the candidate is applied directly with `vec_bridge`=0.
- R6: The cycle after a bridge vector, the held candidate is applied with `vec_valid`=1 and `vec_bridge`=0, and no new count is taken for it.
- R7: Every base pattern is applied exactly once and in order. `vec_valid` stays high on every cycle from the first applied vector to the last, and is never high together with `test_done`.
- R8: For each bridged pair, the bit differences from the previous vector to the bridge, and from the bridge to the candidate, are each no more than the difference between the previous vector and the candidate.
- R9: `test_done` rises on the cycle after the `NUM_PATTERNS`-th base pattern is applied. After that, `test_done` stays high, `vec_valid` stays low and `test_vec` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_vec | output | WIDTH | Vector applied to the circuit under test |
| vec_valid | output | 1 | test_vec carries a new applied vector this cycle |
| vec_bridge | output | 1 | The current vector is an inserted bridge |
| test_done | output | 1 | All base patterns have been applied |

## Verification
The bench runs two instances. One uses the default threshold, where most pairs differ in six bits and are bridged, while the complement at the wrap gives a two-bit pair that passes straight through. The other raises the threshold to exactly six, so a design using greater-or-equal would insert spurious bridges that the scoreboard reports as extra items. A design that advanced the ring on a bridge cycle would skip a base pattern. One that re-checked the held pattern, or built the bridge from the wrong halves, would break the per-bridge transition bound or the exact vector match. Late or early `test_done`, or gaps in `vec_valid`, show up in the done-timing and continuity checks.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;
    typedef enum logic [1:0] {
        ST_CHECK = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DONE  = 2'd2
    } ltpg_state_e;
endpackage

// File: rtl/ltpg_ring_gen.sv
// Base pattern source: rotate left one bit per advance, complement on wrap (R2).
module ltpg_ring_gen #(
    parameter int WIDTH = 8,
    parameter logic [WIDTH-1:0] SEED = 8'b1011_0010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [WIDTH-1:0] pattern
);
    localparam int POS_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WIDTH - 1);

    logic [WIDTH-1:0] ring_q;
    logic [POS_W-1:0] pos_q;
    logic [WIDTH-1:0] rotated;

    assign rotated = {ring_q[WIDTH-2:0], ring_q[WIDTH-1]};
    assign pattern = ring_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= SEED;
            pos_q  <= '0;
        end else if (advance) begin
            if (pos_q == POS_LAST) begin
                ring_q <= ~rotated;
                pos_q  <= '0;
            end else begin
                ring_q <= rotated;
                pos_q  <= pos_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ltpg_toggle_count.sv
// Bitwise XOR followed by an adder chain that sums the toggling positions (R3).
module ltpg_toggle_count #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 4
) (
    input  logic [WIDTH-1:0] vec_a,
    input  logic [WIDTH-1:0] vec_b,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] diff;
    assign diff = vec_a ^ vec_b;

    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + CNT_W'(diff[i]);
        end
    end
endmodule

// File: rtl/ltpg_bridge_mux.sv
// Per-bit selection: upper half from the coming pattern, lower half from the applied one (R4).
module ltpg_bridge_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] prev_vec,
    input  logic [WIDTH-1:0] next_vec,
    output logic [WIDTH-1:0] bridge
);
    localparam int HALF = WIDTH / 2;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= HALF) begin : g_hi
            assign bridge[i] = next_vec[i];
        end else begin : g_lo
            assign bridge[i] = prev_vec[i];
        end
    end
endmodule

// File: rtl/ltpg_top.sv
module ltpg_top #(
    parameter int WIDTH = 8,
    parameter int THRESH = 4,
    parameter int NUM_PATTERNS = 12,
    parameter logic [WIDTH-1:0] SEED = 8'b1011_0010
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] test_vec,
    output logic             vec_valid,
    output logic             vec_bridge,
    output logic             test_done
);
    import ltpg_pkg::*;

    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam int PCNT_W = $clog2(NUM_PATTERNS + 1);
    localparam logic [CNT_W-1:0] THR_C = CNT_W'(THRESH);
    localparam logic [PCNT_W-1:0] LAST_IDX = PCNT_W'(NUM_PATTERNS - 1);

    ltpg_state_e      state_q, state_d;
    logic [WIDTH-1:0] candidate;
    logic [WIDTH-1:0] bridge_vec;
    logic [CNT_W-1:0] toggles;
    logic [PCNT_W-1:0] applied_q;
    logic             over;
    logic             final_pat;
    logic             advance;

    ltpg_ring_gen #(.WIDTH(WIDTH), .SEED(SEED)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .pattern (candidate)
    );

    ltpg_toggle_count #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_count (
        .vec_a (candidate),
        .vec_b (test_vec),
        .count (toggles)
    );

    ltpg_bridge_mux #(.WIDTH(WIDTH)) u_mux (
        .prev_vec (test_vec),
        .next_vec (candidate),
        .bridge   (bridge_vec)
    );

    assign over      = (toggles > THR_C);
    assign final_pat = (applied_q == LAST_IDX);
    assign advance   = ((state_q == ST_CHECK) && !over) || (state_q == ST_HOLD);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CHECK;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CHECK: begin
                if (over)           state_d = ST_HOLD;
                else if (final_pat) state_d = ST_DONE;
                else                state_d = ST_CHECK;
            end
            ST_HOLD:  state_d = final_pat ? ST_DONE : ST_CHECK;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_DONE;
        endcase
    end

    // Registered outputs and applied-pattern counter
    always_ff @(posedge clk) begin
        if (rst) begin
            test_vec   <= '0;
            vec_valid  <= 1'b0;
            vec_bridge <= 1'b0;
            test_done  <= 1'b0;
            applied_q  <= '0;
        end else begin
            unique case (state_q)
                ST_CHECK: begin
                    vec_valid <= 1'b1;
                    if (over) begin
                        test_vec   <= bridge_vec;
                        vec_bridge <= 1'b1;
                    end else begin
                        test_vec   <= candidate;
                        vec_bridge <= 1'b0;
                        applied_q  <= applied_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    test_vec   <= candidate;
                    vec_valid  <= 1'b1;
                    vec_bridge <= 1'b0;
                    applied_q  <= applied_q + 1'b1;
                end
                ST_DONE: begin
                    vec_valid  <= 1'b0;
                    vec_bridge <= 1'b0;
                    test_done  <= 1'b1;
                end
                default: begin
                    vec_valid  <= 1'b0;
                    vec_bridge <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ltpg_checker.sv
module ltpg_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] test_vec,
    input logic             vec_valid,
    input logic             vec_bridge,
    input logic             test_done
);
    localparam int HALF = WIDTH / 2;

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(vec_valid && test_done));

    assert_bridge_valid_R4: assert property (@(posedge clk) disable iff (rst)
        vec_bridge |-> vec_valid);

    assert_bridge_low_R4: assert property (@(posedge clk) disable iff (rst)
        vec_bridge |-> (test_vec[HALF-1:0] == $past(test_vec[HALF-1:0])));

    assert_held_upper_R4: assert property (@(posedge clk) disable iff (rst)
        vec_bridge |=> (test_vec[WIDTH-1:HALF] == $past(test_vec[WIDTH-1:HALF])));

    assert_held_follows_R6: assert property (@(posedge clk) disable iff (rst)
        vec_bridge |=> (vec_valid && !vec_bridge));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        test_done |=> (test_done && !vec_valid && $stable(test_vec)));
endmodule

bind ltpg_top ltpg_checker #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .test_vec   (test_vec),
    .vec_valid  (vec_valid),
    .vec_bridge (vec_bridge),
    .test_done  (test_done)
);

// File: tb/ltpg_top_tb_top.sv
module ltpg_top_tb_top;
    localparam int W = 8;
    localparam int NPAT = 12;
    localparam logic [W-1:0] SEED = 8'b1011_0010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [W-1:0] vec0, vec1;
    logic val0, val1, br0, br1, dn0, dn1;

    ltpg_top #(.WIDTH(W), .THRESH(4), .NUM_PATTERNS(NPAT), .SEED(SEED)) dut_i (
        .clk(clk), .rst(rst), .test_vec(vec0), .vec_valid(val0),
        .vec_bridge(br0), .test_done(dn0));

    ltpg_top #(.WIDTH(W), .THRESH(6), .NUM_PATTERNS(NPAT), .SEED(SEED)) dut_eq (
        .clk(clk), .rst(rst), .test_vec(vec1), .vec_valid(val1),
        .vec_bridge(br1), .test_done(dn1));

    // Expected item: {bridge flag, held-after-bridge flag, vector}
    logic [W+1:0] q0[$];
    logic [W+1:0] q1[$];

    int n_cmp = 0;
    int n_bad = 0;

    logic [W-1:0] last_vec [2];
    logic [W-1:0] pre_br   [2];
    bit last_br [2];
    bit started [2];
    bit done_seen [2];
    bit last_valid [2];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: compute expected applied stream from the requirements
    task automatic load_expected(input int id, input int thr);
        logic [W-1:0] base, prev, rot, brg;
        int pos, cnt;
        base = SEED; prev = '0; pos = 0;
        for (int k = 0; k < NPAT; k++) begin
            cnt = $countones(base ^ prev);              // R3
            if (cnt > thr) begin                        // R4
                brg = {base[W-1:W/2], prev[W/2-1:0]};
                if (id == 0) begin q0.push_back({1'b1, 1'b0, brg}); q0.push_back({1'b0, 1'b1, base}); end
                else         begin q1.push_back({1'b1, 1'b0, brg}); q1.push_back({1'b0, 1'b1, base}); end
            end else begin                              // R5
                if (id == 0) q0.push_back({1'b0, 1'b0, base});
                else         q1.push_back({1'b0, 1'b0, base});
            end
            prev = base;
            rot = {base[W-2:0], base[W-1]};             // R2
            if (pos == W - 1) begin base = ~rot; pos = 0; end
            else begin base = rot; pos++; end
        end
    endtask

    // Monitor: pop and compare one observed cycle
    task automatic observe(input int id, input logic [W-1:0] v, input logic vl,
                           input logic b, input logic d);
        logic [W+1:0] item;
        string tag;
        if (d && !done_seen[id]) begin
            check(last_valid[id], "R9 done one cycle after last pattern", 0, 1);
            done_seen[id] = 1;
        end
        if (started[id] && !done_seen[id] && !vl)
            check(0, "R7 gap in vec_valid", 0, 1);
        if (vl && d) check(0, "R7 valid with done", 1, 0);
        if (vl) begin
            started[id] = 1;
            if ((id == 0 && q0.size() == 0) || (id == 1 && q1.size() == 0)) begin
                check(0, "R7 extra vector", int'(v), 0);
            end else begin
                item = (id == 0) ? q0.pop_front() : q1.pop_front();
                if (item[W+1])      tag = "R3 R4 bridge";
                else if (item[W])   tag = "R6 held pattern";
                else                tag = "R2 R5 direct";
                check(v == item[W-1:0] && b == item[W+1], tag,
                      int'({b, v}), int'({item[W+1], item[W-1:0]}));
                if (last_br[id]) begin
                    check($countones(pre_br[id] ^ last_vec[id]) <= $countones(pre_br[id] ^ v),
                          "R8 prev-to-bridge", $countones(pre_br[id] ^ last_vec[id]),
                          $countones(pre_br[id] ^ v));
                    check($countones(last_vec[id] ^ v) <= $countones(pre_br[id] ^ v),
                          "R8 bridge-to-next", $countones(last_vec[id] ^ v),
                          $countones(pre_br[id] ^ v));
                end
                pre_br[id]  = last_vec[id];
                last_br[id] = b;
                last_vec[id] = v;
            end
        end
        last_valid[id] = vl;
    endtask

    bit running = 0;
    always @(negedge clk) begin
        if (running) begin
            observe(0, vec0, val0, br0, dn0);
            observe(1, vec1, val1, br1, dn1);
        end
    end

    initial begin
        int wd;
        logic [W-1:0] hold0;
        for (int i = 0; i < 2; i++) begin
            last_vec[i] = '0; pre_br[i] = '0; last_br[i] = 0;
            started[i] = 0; done_seen[i] = 0; last_valid[i] = 0;
        end
        load_expected(0, 4);
        load_expected(1, 6);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(vec0 == '0 && !val0 && !br0 && !dn0, "R1 reset state dut_i", int'({dn0, br0, val0, vec0}), 0);
        check(vec1 == '0 && !val1 && !br1 && !dn1, "R1 reset state dut_eq", int'({dn1, br1, val1, vec1}), 0);
        rst = 1'b0;
        running = 1;
        wd = 0;
        while (!(done_seen[0] && done_seen[1]) && wd < 2000) begin
            @(posedge clk);
            wd++;
        end
        if (wd >= 2000) check(0, "R9 watchdog expired", wd, 0);
        @(negedge clk);
        hold0 = vec0;
        repeat (5) begin
            @(negedge clk);
            check(dn0 && !val0 && vec0 == hold0, "R9 frozen after done", int'({dn0, val0, vec0}), int'({1'b1, 1'b0, hold0}));
        end
        running = 0;
        check(q0.size() == 0, "R7 all patterns applied dut_i", q0.size(), 0);
        check(q1.size() == 0, "R7 all patterns applied dut_eq", q1.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule